// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block is a cycle-level model of one data channel that crosses an isolation barrier by sending transitions only. On the transmit side, an encoder watches a single data input. It emits a one-cycle pulse on a "set" wire when the input rises and on a "clear" wire when it falls. While the input stays quiet, the encoder restates the current level with a refresh pulse at a fixed interval, so the far side can never drift away from the true DC level.

On the receive side, a bistable latch follows the set and clear pulses. A watchdog times the gap since the last good pulse. When the gap grows too long, the sender is treated as dead: a link-valid flag drops and the data output is forced to a configured safe level. The next good pulse brings the link back and restores the signalled level. Both halves share one clock domain here. The pulse wires leave and enter the block as ports, so the barrier sits outside it.

The refresh interval and the watchdog timeout are set in clock cycles. The timeout must be longer than the refresh interval, so a live but quiet sender never trips the watchdog.

Top module: `iso_pulse_channel`

## Requirements
- R1: A rising edge on `din` produces `set_pulse` high for exactly one cycle, in the cycle after the edge is sampled. A falling edge does the same on `clr_pulse`.
- R2: `set_pulse` and `clr_pulse` are never high in the same cycle. A high `set_pulse` means level 1 and a high `clr_pulse` means level 0.
- R3: With no edge on `din`, the encoder emits a refresh pulse carrying the current `din` level exactly REFRESH_CYCLES cycles after its previous pulse, and keeps doing so.
- R4: A received pulse with only `link_set_in` high sets `dout` to 1 one cycle later. A pulse with only `link_clr_in` high sets it to 0 one cycle later.
- R5: A cycle in which `link_set_in` and `link_clr_in` are both high is ignored. It changes neither the latched level nor `link_ok`, and it does not restart the watchdog.
- R6: When WDOG_CYCLES cycles pass after the last valid received pulse with no new valid pulse, `link_ok` goes low and `dout` equals DEFAULT_LEVEL until a valid pulse arrives.
- R7: The first valid pulse after expiry or reset raises `link_ok` and drives `dout` to the signalled level one cycle later.
- R8: While `rst_n` is low and after its release, `dout` is DEFAULT_LEVEL, `link_ok` is low, and both pulse outputs are low until the encoder's first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for encoder and decoder |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Data level to be carried across |
| set_pulse | output | 1 | Encoder pulse meaning level 1 |
| clr_pulse | output | 1 | Encoder pulse meaning level 0 |
| link_set_in | input | 1 | Received pulse meaning level 1 |
| link_clr_in | input | 1 | Received pulse meaning level 0 |
| dout | output | 1 | Reconstructed data level |
| link_ok | output | 1 | High while the sender is considered alive |

## Verification
A wrong latch value shows on `dout` one cycle after the pulse that should have set it, provided the watchdog is still live. A wrong watchdog count shows as `link_ok` falling early or late against the exact cycle WDOG_CYCLES after the last good pulse. A wrong refresh counter shows as a refresh pulse that is off by one or more cycles from the REFRESH_CYCLES grid measured from the previous pulse. A collision that leaks into the decoder shows at once: either `dout` flips or `link_ok` comes back while it should stay low.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // Meaning of one cycle on the two-wire pulse link.
  typedef enum logic [1:0] {
    LNK_IDLE = 2'b00,
    LNK_SET  = 2'b01,
    LNK_CLR  = 2'b10,
    LNK_BAD  = 2'b11
  } link_sym_e;

  function automatic link_sym_e classify(input logic set_w, input logic clr_w);
    return link_sym_e'({clr_w, set_w});
  endfunction

  function automatic logic is_good(input link_sym_e sym);
    return (sym == LNK_SET) || (sym == LNK_CLR);
  endfunction

  function automatic logic latch_next(input logic q, input link_sym_e sym);
    case (sym)
      LNK_SET: return 1'b1;
      LNK_CLR: return 1'b0;
      default: return q;
    endcase
  endfunction

  // True when a cycle counter has reached the final count of its window.
  function automatic logic at_last(input int unsigned cnt, input int unsigned window);
    return cnt == (window - 1);
  endfunction

endpackage

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder #(
  parameter int REFRESH_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic set_o,
  output logic clr_o
);
  localparam int RCW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;

  logic           din_q;
  logic [RCW-1:0] quiet_cnt;
  logic           edge_seen;
  logic           refresh_due;
  logic           emit;

  assign edge_seen   = din ^ din_q;
  assign refresh_due = iso_link_pkg::at_last(32'(quiet_cnt), REFRESH_CYCLES);
  assign emit        = edge_seen | refresh_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q     <= 1'b0;
      quiet_cnt <= '0;
      set_o     <= 1'b0;
      clr_o     <= 1'b0;
    end else begin
      din_q     <= din;
      set_o     <= emit & din;
      clr_o     <= emit & ~din;
      quiet_cnt <= emit ? '0 : quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/iso_sr_latch.sv
module iso_sr_latch #(
  parameter logic DEFAULT_LEVEL = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  iso_link_pkg::link_sym_e sym,
  output logic                    q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= DEFAULT_LEVEL;
    else        q <= iso_link_pkg::latch_next(q, sym);
  end
endmodule

// File: rtl/iso_watchdog.sv
module iso_watchdog #(
  parameter int WDOG_CYCLES = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  iso_link_pkg::link_sym_e sym,
  output logic                    valid_o
);
  localparam int WCW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;

  logic [WCW-1:0] gap_cnt;
  logic           good;
  logic           expire;

  assign good   = iso_link_pkg::is_good(sym);
  assign expire = valid_o & ~good & iso_link_pkg::at_last(32'(gap_cnt), WDOG_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      gap_cnt <= '0;
    end else if (good) begin
      valid_o <= 1'b1;
      gap_cnt <= '0;
    end else if (expire) begin
      valid_o <= 1'b0;
      gap_cnt <= '0;
    end else if (valid_o) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/iso_pulse_channel.sv
module iso_pulse_channel #(
  parameter int   REFRESH_CYCLES = 200,
  parameter int   WDOG_CYCLES    = 1000,
  parameter logic DEFAULT_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic set_pulse,
  output logic clr_pulse,
  input  logic link_set_in,
  input  logic link_clr_in,
  output logic dout,
  output logic link_ok
);
  iso_link_pkg::link_sym_e rx_sym;
  logic                    rx_level;
  logic                    wd_valid;

  assign rx_sym = iso_link_pkg::classify(link_set_in, link_clr_in);

  iso_edge_encoder #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .set_o (set_pulse),
    .clr_o (clr_pulse)
  );

  iso_sr_latch #(.DEFAULT_LEVEL(DEFAULT_LEVEL)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .sym   (rx_sym),
    .q     (rx_level)
  );

  iso_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym     (rx_sym),
    .valid_o (wd_valid)
  );

  assign link_ok = wd_valid;

  // The safe level picks the output gating.
  if (DEFAULT_LEVEL) begin : g_safe_high
    assign dout = ~wd_valid | rx_level;
  end else begin : g_safe_low
    assign dout = wd_valid & rx_level;
  end
endmodule

// File: rtl/iso_channel_chk.sv
module iso_channel_chk #(
  parameter int   REFRESH_CYCLES = 200,
  parameter int   WDOG_CYCLES    = 1000,
  parameter logic DEFAULT_LEVEL  = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic set_pulse,
  input logic clr_pulse,
  input logic link_set_in,
  input logic link_clr_in,
  input logic dout,
  input logic link_ok
);
  localparam int QCW = $clog2(REFRESH_CYCLES + 2);

  logic [QCW-1:0] quiet_seen;

  // Cycles since the encoder last pulsed, saturating one past the interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      quiet_seen <= '0;
    else if (set_pulse || clr_pulse)                 quiet_seen <= '0;
    else if (32'(quiet_seen) <= REFRESH_CYCLES)      quiet_seen <= quiet_seen + 1'b1;
  end

  initial begin
    a_r6_timeout_exceeds_refresh: assert (WDOG_CYCLES > REFRESH_CYCLES);
  end

  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(din) |=> set_pulse);

  a_r1_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(din) |=> clr_pulse);

  a_r2_wires_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_pulse && clr_pulse));

  a_r3_refresh_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(quiet_seen) <= REFRESH_CYCLES);

  a_r4_set_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (link_set_in && !link_clr_in) |=> (dout && link_ok));

  a_r4_clr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clr_in && !link_set_in) |=> (!dout && link_ok));

  a_r5_no_revive: assert property (@(posedge clk) disable iff (!rst_n)
    (link_set_in && link_clr_in) |=> !$rose(link_ok));

  a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (link_set_in && link_clr_in) |=> (!link_ok || $stable(dout)));

  a_r6_default_when_dead: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |-> (dout == DEFAULT_LEVEL));
endmodule

bind iso_pulse_channel iso_channel_chk #(
  .REFRESH_CYCLES (REFRESH_CYCLES),
  .WDOG_CYCLES    (WDOG_CYCLES),
  .DEFAULT_LEVEL  (DEFAULT_LEVEL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .din         (din),
  .set_pulse   (set_pulse),
  .clr_pulse   (clr_pulse),
  .link_set_in (link_set_in),
  .link_clr_in (link_clr_in),
  .dout        (dout),
  .link_ok     (link_ok)
);

// File: tb/test_iso_pulse_channel.sv
`timescale 1ns/1ps
module test_iso_pulse_channel;
  localparam int   RC  = 8;
  localparam int   WD  = 20;
  localparam logic DEF = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic inj = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic set_pulse, clr_pulse, dout, link_ok;
  logic link_set_in, link_clr_in;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2.5 clk = ~clk;

  assign link_set_in = inj ? inj_set : set_pulse;
  assign link_clr_in = inj ? inj_clr : clr_pulse;

  iso_pulse_channel #(.REFRESH_CYCLES(RC), .WDOG_CYCLES(WD), .DEFAULT_LEVEL(DEF)) i_iso_pulse_channel (
    .clk(clk), .rst_n(rst_n), .din(din),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .link_set_in(link_set_in), .link_clr_in(link_clr_in),
    .dout(dout), .link_ok(link_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    // R8: state held in reset
    step(3);
    check("R8 dout in reset", dout, DEF);
    check("R8 link_ok in reset", link_ok, 0);
    check("R8 pulses in reset", set_pulse | clr_pulse, 0);
    rst_n = 1'b1;
    for (int k = 1; k < RC; k++) begin
      step(1);
      check("R8 no pulse before first refresh", set_pulse | clr_pulse, 0);
      check("R8 link_ok low before first pulse", link_ok, 0);
    end
    step(1);
    check("R3 first refresh carries level 0", clr_pulse, 1);
    check("R2 set idle on refresh 0", set_pulse, 0);
    step(1);
    check("R7 link comes up", link_ok, 1);
    check("R7 level after bring-up", dout, 0);

    // R1/R2/R4: edge sweep with gaps of every length from 2 to 13
    for (int g = 2; g <= 13; g++) begin
      din = ~din;
      step(1);
      check("R1 pulse on matching wire", din ? set_pulse : clr_pulse, 1);
      check("R2 other wire idle", din ? clr_pulse : set_pulse, 0);
      step(1);
      check("R4 dout follows pulse", dout, din);
      check("R1 pulse one cycle wide", set_pulse | clr_pulse, 0);
      step(g - 2);
    end

    // R3: refresh grid after an edge, for both levels, two periods each
    for (int lv = 0; lv < 2; lv++) begin
      din = ~din;
      step(1);
      check("R1 edge pulse before refresh run", set_pulse | clr_pulse, 1);
      for (int per = 0; per < 2; per++) begin
        for (int k = 1; k < RC; k++) begin
          step(1);
          check("R3 quiet between refreshes", set_pulse | clr_pulse, 0);
          check("R3 dout stays correct", dout, din);
        end
        step(1);
        check("R3 refresh on level wire", din ? set_pulse : clr_pulse, 1);
        check("R2 refresh other wire idle", din ? clr_pulse : set_pulse, 0);
      end
    end

    // R6: silence the link right after a set pulse is consumed
    din = 1'b0;
    step(3);
    din = 1'b1;
    step(1);
    check("R1 set before silence", set_pulse, 1);
    step(1);
    inj = 1'b1;
    for (int k = 1; k < WD; k++) begin
      step(1);
      check("R6 link alive inside window", link_ok, 1);
      check("R6 level kept inside window", dout, 1);
    end
    step(1);
    check("R6 link drops at timeout", link_ok, 0);
    check("R6 dout forced to default", dout, DEF);
    step(5);
    check("R6 stays expired", link_ok, 0);

    // R5: collision while expired
    inj_set = 1'b1; inj_clr = 1'b1;
    step(1);
    inj_set = 1'b0; inj_clr = 1'b0;
    check("R5 collision does not revive", link_ok, 0);
    check("R5 collision keeps default", dout, DEF);

    // R7/R4: recovery by injected pulses
    inj_set = 1'b1; step(1); inj_set = 1'b0;
    check("R7 link restored", link_ok, 1);
    check("R7 level restored", dout, 1);
    inj_clr = 1'b1; step(1); inj_clr = 1'b0;
    check("R4 clear pulse", dout, 0);
    inj_set = 1'b1; step(1); inj_set = 1'b0;
    check("R4 set pulse", dout, 1);

    // R5: a collision late in the window neither flips nor restarts
    step(WD - 3);
    inj_set = 1'b1; inj_clr = 1'b1;
    step(1);
    inj_set = 1'b0; inj_clr = 1'b0;
    check("R5 collision holds level", dout, 1);
    check("R5 collision holds link", link_ok, 1);
    step(1);
    check("R5 link still alive", link_ok, 1);
    step(1);
    check("R5 watchdog not restarted", link_ok, 0);
    check("R6 default after timeout", dout, DEF);

    // R7: reconnect the encoder; a refresh revives the link
    inj = 1'b0;
    step(RC + 1);
    check("R7 refresh revives link", link_ok, 1);
    check("R7 revived level", dout, din);

    summary();
    $finish;
  end
endmodule